// File: doc/BRIEF.md
# Interleaved I/Q Input Demultiplexer

This block takes one data bus that carries I and Q words one after the other at the full rate of its input clock. It sorts the words into two holding registers, and a select line picks the register for each word. An internal phase signal runs at half the input clock rate. It moves each completed pair into two output words on a single edge, so the I and Q of a sample always leave together. A synchronisation input keeps the phase low and freezes both outputs. The cycle on which this input is released decides which two words form a pair, so the system can swap I and Q by releasing it in the other select phase.

A mode input can instead split the block into two independent channels. Each channel then has its own clock, write strobe and data bus, and each delays its words by the same fixed latency. The output words are registered, and a mode multiplexer picks between the interleaved path and the per-channel paths. Reset is synchronous and active-high. It is sampled by each clock domain that it clears.

Top module: `iq_interleave_demux`

## Requirements
- R1: In interleaved mode (`mode_dual` = 0), at a rising `clk_a` edge where `wr_a` is 1, `data_a` is stored in holding register A if `sel` is 1, or in holding register B if `sel` is 0.
- R2: At a rising `clk_a` edge where `wr_a` is 0, neither holding register changes, so the outputs keep repeating the last stored pair.
- R3: While `sync` is low, the half-rate phase rises at the first `clk_a` edge that samples `sync` low and then toggles on every edge. A pair transfer happens on each edge that samples the phase high, which is every second edge.
- R4: At any edge that samples `sync` high, the phase is forced low and `out_a` and `out_b` do not change. The holding registers keep accepting writes, and words written in this time reach the outputs after release.
- R5: `out_a` and `out_b` change only on transfer edges, and both are loaded on the same edge.
- R6: If `sync` is first sampled low on an edge with `sel` = 0, each output pair holds an A word and the B word written on the edge after it. The A word reaches the outputs exactly 4 `clk_a` edges after its write edge.
- R7: If `sync` is first sampled low on an edge with `sel` = 1, the pairing is exchanged: each B word is paired with the A word written on the edge after it. The B word reaches the outputs exactly 4 edges after its write edge.
- R8: In dual mode (`mode_dual` = 1), `out_a` equals the `data_a` word stored (with `wr_a` = 1) 4 `clk_a` edges earlier, and `out_b` equals the `data_b` word stored (with `wr_b` = 1) 4 `clk_b` edges earlier. The two channels run independently, and `sync` and `sel` have no effect.
- R9: A `rst` of 1 clears the holding registers, the pipelines and both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Input clock; the only clock in interleaved mode, channel A clock in dual mode |
| clk_b | input | 1 | Channel B clock, used in dual mode only |
| rst | input | 1 | Synchronous active-high reset |
| mode_dual | input | 1 | 0 = interleaved single bus, 1 = two independent channels |
| sync | input | 1 | High holds the half-rate phase low and freezes the outputs |
| sel | input | 1 | Interleaved mode: 1 writes register A, 0 writes register B |
| wr_a | input | 1 | Write strobe for the shared bus / channel A |
| wr_b | input | 1 | Write strobe for channel B in dual mode |
| data_a | input | DW | Shared interleaved bus / channel A data |
| data_b | input | DW | Channel B data in dual mode |
| out_a | output | DW | I output word / channel A output |
| out_b | output | DW | Q output word / channel B output |

## Verification
Some behaviours are checked by the assertions on every `clk_a` edge: the phase is held low under `sync` and toggles otherwise, each write lands in the register that `sel` picks, the outputs stay frozen while `sync` is high, and the two outputs move only on an edge the phase allows. Other behaviours only the directed scenarios can show. These are the exact pairing and four-edge latency after a release in either select phase, the repeat of a pair after the strobe stops, and the fixed delay of each channel in dual mode under two unrelated clocks.

// File: rtl/iqd_pkg.sv
package iqd_pkg;
  typedef enum logic {
    IQD_INTERLEAVED = 1'b0,
    IQD_DUAL        = 1'b1
  } iqd_mode_e;
endpackage

// File: rtl/iqd_word_reg.sv
module iqd_word_reg #(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/iqd_phase_gen.sv
module iqd_phase_gen (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic phase,
  output logic xfer
);
  // Half-rate phase: forced low while hold is high, toggles otherwise.
  always_ff @(posedge clk) begin
    if (rst || hold) phase <= 1'b0;
    else             phase <= ~phase;
  end

  // A transfer occurs on the edge that samples the phase high, unless frozen.
  assign xfer = phase & ~hold;
endmodule

// File: rtl/iqd_xfer_pipe.sv
module iqd_xfer_pipe #(
  parameter int DW     = 14,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  output logic [DW-1:0] out_a,
  output logic [DW-1:0] out_b
);
  typedef struct packed {
    logic [DW-1:0] a;
    logic [DW-1:0] b;
  } pair_t;

  pair_t in_pair;
  assign in_pair = '{a: in_a, b: in_b};

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    pair_t q;
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (adv) q <= in_pair;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (adv) q <= g_stage[s-1].q;
      end
    end
  end

  assign out_a = g_stage[STAGES-1].q.a;
  assign out_b = g_stage[STAGES-1].q.b;
endmodule

// File: rtl/iqd_lane.sv
module iqd_lane #(
  parameter int DW    = 14,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  logic [DW-1:0] held;

  iqd_word_reg #(.DW(DW)) u_hold (
    .clk (clk),
    .rst (rst),
    .we  (we),
    .d   (d),
    .q   (held)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_dly
    logic [DW-1:0] r;
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= held;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= g_dly[i-1].r;
      end
    end
  end

  assign q = g_dly[DEPTH-1].r;
endmodule

// File: rtl/iq_interleave_demux.sv
module iq_interleave_demux
  import iqd_pkg::*;
#(
  parameter int DW      = 14,
  parameter int LATENCY = 4
) (
  input  logic          clk_a,
  input  logic          clk_b,
  input  logic          rst,
  input  logic          mode_dual,
  input  logic          sync,
  input  logic          sel,
  input  logic          wr_a,
  input  logic          wr_b,
  input  logic [DW-1:0] data_a,
  input  logic [DW-1:0] data_b,
  output logic [DW-1:0] out_a,
  output logic [DW-1:0] out_b
);
  localparam int XFER_STAGES = LATENCY / 2;
  localparam int LANE_DEPTH  = LATENCY;
  localparam int NUM_LANES   = 2;

  iqd_mode_e mode;
  assign mode = iqd_mode_e'(mode_dual);

  // Interleaved path
  logic          xfer_ph;
  logic          xfer_en;
  logic [DW-1:0] il_hold_a;
  logic [DW-1:0] il_hold_b;
  logic [DW-1:0] il_out_a;
  logic [DW-1:0] il_out_b;

  iqd_phase_gen u_phase (
    .clk   (clk_a),
    .rst   (rst),
    .hold  (sync),
    .phase (xfer_ph),
    .xfer  (xfer_en)
  );

  iqd_word_reg #(.DW(DW)) u_hold_a (
    .clk (clk_a),
    .rst (rst),
    .we  (wr_a & sel),
    .d   (data_a),
    .q   (il_hold_a)
  );

  iqd_word_reg #(.DW(DW)) u_hold_b (
    .clk (clk_a),
    .rst (rst),
    .we  (wr_a & ~sel),
    .d   (data_a),
    .q   (il_hold_b)
  );

  iqd_xfer_pipe #(.DW(DW), .STAGES(XFER_STAGES)) u_xfer (
    .clk   (clk_a),
    .rst   (rst),
    .adv   (xfer_en),
    .in_a  (il_hold_a),
    .in_b  (il_hold_b),
    .out_a (il_out_a),
    .out_b (il_out_b)
  );

  // Dual-channel path
  logic [DW-1:0] lane_q [NUM_LANES];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    iqd_lane #(.DW(DW), .DEPTH(LANE_DEPTH)) u_lane (
      .clk (g == 0 ? clk_a  : clk_b),
      .rst (rst),
      .we  (g == 0 ? wr_a   : wr_b),
      .d   (g == 0 ? data_a : data_b),
      .q   (lane_q[g])
    );
  end

  assign out_a = (mode == IQD_DUAL) ? lane_q[0] : il_out_a;
  assign out_b = (mode == IQD_DUAL) ? lane_q[1] : il_out_b;
endmodule

// File: rtl/iqd_checker.sv
module iqd_checker #(
  parameter int DW = 14
) (
  input logic          clk_a,
  input logic          rst,
  input logic          mode_dual,
  input logic          sync,
  input logic          sel,
  input logic          wr_a,
  input logic [DW-1:0] data_a,
  input logic [DW-1:0] out_a,
  input logic [DW-1:0] out_b,
  input logic          ph,
  input logic          xfer,
  input logic [DW-1:0] hold_a,
  input logic [DW-1:0] hold_b
);
  assert_phase_low_R4: assert property (@(posedge clk_a) disable iff (rst)
    sync |=> !ph);

  assert_phase_toggle_R3: assert property (@(posedge clk_a) disable iff (rst)
    !sync |=> (ph != $past(ph)));

  assert_store_a_R1: assert property (@(posedge clk_a) disable iff (rst)
    (wr_a && sel) |=> (hold_a == $past(data_a)));

  assert_store_b_R1: assert property (@(posedge clk_a) disable iff (rst)
    (wr_a && !sel) |=> (hold_b == $past(data_a)));

  assert_frozen_R4: assert property (@(posedge clk_a) disable iff (rst)
    (!mode_dual && sync) |=> (mode_dual || ($stable(out_a) && $stable(out_b))));

  assert_move_on_xfer_R5: assert property (@(posedge clk_a) disable iff (rst)
    (!mode_dual && $past(!mode_dual) && (!$stable(out_a) || !$stable(out_b)))
      |-> $past(xfer));
endmodule

bind iq_interleave_demux iqd_checker #(.DW(DW)) u_chk (
  .clk_a     (clk_a),
  .rst       (rst),
  .mode_dual (mode_dual),
  .sync      (sync),
  .sel       (sel),
  .wr_a      (wr_a),
  .data_a    (data_a),
  .out_a     (out_a),
  .out_b     (out_b),
  .ph        (xfer_ph),
  .xfer      (xfer_en),
  .hold_a    (il_hold_a),
  .hold_b    (il_hold_b)
);

// File: tb/iq_interleave_demux_tb.sv
module iq_interleave_demux_tb;
  localparam int DW       = 14;
  localparam int LAT      = 4;
  localparam int CLK_A_P  = 10;
  localparam int CLK_B_P  = 14;

  logic          clk_a = 1'b0;
  logic          clk_b = 1'b0;
  logic          rst = 1'b1;
  logic          mode_dual = 1'b0;
  logic          sync = 1'b1;
  logic          sel = 1'b0;
  logic          wr_a = 1'b0;
  logic          wr_b = 1'b0;
  logic [DW-1:0] data_a = '0;
  logic [DW-1:0] data_b = '0;
  logic [DW-1:0] out_a;
  logic [DW-1:0] out_b;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #(CLK_A_P/2) clk_a = ~clk_a;
  always #(CLK_B_P/2) clk_b = ~clk_b;

  iq_interleave_demux #(.DW(DW), .LATENCY(LAT)) u_dut (
    .clk_a(clk_a), .clk_b(clk_b), .rst(rst), .mode_dual(mode_dual),
    .sync(sync), .sel(sel), .wr_a(wr_a), .wr_b(wr_b),
    .data_a(data_a), .data_b(data_b), .out_a(out_a), .out_b(out_b)
  );

  task automatic check_pair(string tag, logic [DW-1:0] ea, logic [DW-1:0] eb);
    n_checks++;
    if (out_a !== ea || out_b !== eb) begin
      n_fail++;
      $display("FAIL %s: out_a=%0h out_b=%0h expected %0h %0h", tag, out_a, out_b, ea, eb);
    end
  endtask

  task automatic check_word(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // R9: reset clears outputs
  task automatic do_reset(bit dual);
    @(negedge clk_a);
    rst = 1'b1; mode_dual = dual; sync = 1'b1; sel = 1'b0;
    wr_a = 1'b0; wr_b = 1'b0; data_a = '1; data_b = '1;
    repeat (6) @(negedge clk_a);
    check_pair("R9 reset", '0, '0);
    rst = 1'b0;
  endtask

  // Interleaved stream; sync first sampled low at edge rel, high again from edge frz.
  // Word written before edge j is base+j; sel=1 on even j.
  task automatic run_stream(int rel, int frz, int n, logic [DW-1:0] base, string tag);
    do_reset(1'b0);
    for (int j = 0; j <= n; j++) begin
      @(negedge clk_a);
      if (j >= 1) begin
        int e = j - 1;
        logic [DW-1:0] ea = '0;
        logic [DW-1:0] eb = '0;
        if (e >= rel + LAT - 1) begin
          int ee = (e < frz) ? e : frz - 1;
          int m  = (ee - rel - (LAT - 1)) / 2;
          int i0 = rel - 1 + 2 * m;
          int i1 = rel + 2 * m;
          if (i0 % 2 == 0) begin ea = base + DW'(i0); eb = base + DW'(i1); end
          else             begin ea = base + DW'(i1); eb = base + DW'(i0); end
        end
        check_pair((e >= frz) ? "R4 frozen" : tag, ea, eb);
      end
      sel    = (j % 2 == 0);
      data_a = base + DW'(j);
      wr_a   = 1'b1;
      sync   = (j < rel || j >= frz);
    end
    wr_a = 1'b0;
  endtask

  // R2: strobe low stops capture
  task automatic run_hold();
    logic [DW-1:0] base = 14'h0200;
    do_reset(1'b0);
    for (int j = 0; j < 18; j++) begin
      @(negedge clk_a);
      if (j >= 9) check_pair("R2 strobe low keeps pair", base + 2, base + 3);
      sel    = (j % 2 == 0);
      data_a = base + DW'(j);
      wr_a   = (j < 4);
      sync   = (j < 1);
    end
    wr_a = 1'b0;
  endtask

  // R8: two independent channels, different clocks
  task automatic run_dual();
    do_reset(1'b1);
    fork
      begin
        for (int j = 0; j <= 14; j++) begin
          @(negedge clk_a);
          if (j >= 1) begin
            int e = j - 1;
            check_word("R8 channel A", out_a, (e >= LAT) ? 14'h1100 + DW'(e - LAT) : '0);
          end
          data_a = 14'h1100 + DW'(j); wr_a = 1'b1;
          sel = j[0]; sync = j[1];
        end
        wr_a = 1'b0;
      end
      begin
        for (int j = 0; j <= 10; j++) begin
          @(negedge clk_b);
          if (j >= 1) begin
            int e = j - 1;
            check_word("R8 channel B", out_b, (e >= LAT) ? 14'h2A00 + DW'(e - LAT) : '0);
          end
          data_b = 14'h2A00 + DW'(j); wr_b = 1'b1;
        end
        wr_b = 1'b0;
      end
    join
  endtask

  initial begin
    run_stream(5, 40, 48, 14'h0100, "R1 R3 R5 R6 normal pairing");
    run_stream(6, 41, 48, 14'h0A00, "R1 R3 R5 R7 swapped pairing");
    run_hold();
    run_dual();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_A_P * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule